// File: doc/BRIEF.md
# Ready-Time Ordered Response Queue

This block holds responses that will become ready at known future cycle times. It releases them on a single output port in order of ready time. Each entry is a ready time and a payload tag. A producer offers an entry over a valid/ready handshake together with a flag saying whether a reply is wanted. Entries that want no reply are accepted but thrown away. Stored entries are kept sorted by ready time in a shift register, so an insertion finishes in one cycle. An entry whose time is not below the current tail's time takes the append path.

The head entry is shown on the output once the free-running cycle count `now_i` reaches its ready time. It leaves when the consumer accepts it. The queue also keeps a running sum of miss latencies: for each accepted entry marked as a cacheable miss, the ready time minus the request's issue time is added to it. An enqueue whose ready time already lies in the past raises an error flag.

Top module: `rq_resp_queue`

## Requirements
- R1: After reset, empty_o is 1, deq_valid_o is 0, enq_ready_o is 1 and lat_acc_o is 0.
- R2: deq_valid_o is 1 exactly when the queue holds an entry and now_i is greater than or equal to the head entry's ready time; deq_tag_o carries the head tag; the head is removed on a clock edge where deq_valid_o and deq_ready_i are both 1.
- R3: An enqueue accepted with enq_need_rsp_i = 0 is not stored: occupancy, empty_o and deq_valid_o are unchanged by it.
- R4: An entry enqueued into an empty queue with ready time T is not presented while now_i < T, and is presented from the first cycle after the enqueue edge in which now_i >= T.
- R5: An entry whose ready time is greater than or equal to the tail entry's ready time is placed at the tail, so entries with equal time leave in arrival order.
- R6: Any other entry is inserted once, directly ahead of the first stored entry whose ready time is strictly greater, including ahead of the current head.
- R7: late_err_o is 1 in any cycle where enq_valid_i is 1 and enq_time_i < now_i, and 0 otherwise; a late entry is still stored and released like any other.
- R8: On each accepted enqueue with enq_miss_i = 1 and enq_cacheable_i = 1, lat_acc_o increases by enq_time_i - enq_issue_i (modulo 2^ACC_W) on the next edge, whether or not a response is needed; other enqueues leave it unchanged.
- R9: enq_ready_o is 0 while DEPTH entries are held, and an enqueue offered then is not taken; empty_o is 1 exactly when no entry is held.
- R10: An enqueue and a dequeue on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_i | input | TIME_W | Current cycle count |
| enq_valid_i | input | 1 | Enqueue offer |
| enq_ready_o | output | 1 | Queue can accept an entry |
| enq_time_i | input | TIME_W | Ready time of the offered entry |
| enq_tag_i | input | TAG_W | Payload tag of the offered entry |
| enq_need_rsp_i | input | 1 | Entry wants a reply; 0 means drop |
| enq_miss_i | input | 1 | Entry completes a miss |
| enq_cacheable_i | input | 1 | Request was cacheable |
| enq_issue_i | input | TIME_W | Issue time of the originating request |
| deq_valid_o | output | 1 | Head entry is due |
| deq_ready_i | input | 1 | Consumer accepts the head |
| deq_tag_o | output | TAG_W | Head payload tag |
| empty_o | output | 1 | No entry held |
| late_err_o | output | 1 | Offered ready time is before now_i |
| lat_acc_o | output | ACC_W | Accumulated miss latency |

## Verification
The assertions assume that now_i never decreases and never wraps within a run. They also assume that enq_time_i and the ready times already stored stay comparable as plain unsigned numbers. The hold check on a stalled head additionally assumes that no enqueue is offered in the stalled cycle, since a late entry may legally overtake the head. The directed stimulus raises now_i step by step and keeps every time well below 2^TIME_W. In its stall and overtake cases it never offers an enqueue while a due head is being held back.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    INS_DROP   = 2'd0,
    INS_EMPTY  = 2'd1,
    INS_APPEND = 2'd2,
    INS_MIDDLE = 2'd3
  } ins_kind_e;
endpackage

// File: rtl/rq_place.sv
module rq_place
  import rq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [TIME_W-1:0] slot_time_i [DEPTH],
  input  logic [CNT_W-1:0]  count_i,
  input  logic [TIME_W-1:0] new_time_i,
  input  logic              push_i,
  input  logic              need_i,
  input  logic              pop_i,
  output ins_kind_e         kind_o,
  output logic [CNT_W-1:0]  pos_o
);
  logic [DEPTH-1:0] gt;
  logic [DEPTH-1:0] gt_post;
  logic [CNT_W-1:0] count_post;
  logic [CNT_W-1:0] pos_mid;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign gt[i] = (CNT_W'(i) < count_i) && (slot_time_i[i] > new_time_i);
  end

  // strictly-greater mask as seen after this cycle's pop
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    if (i == DEPTH - 1) begin : g_last
      assign gt_post[i] = pop_i ? 1'b0 : gt[i];
    end else begin : g_mid
      assign gt_post[i] = pop_i ? gt[i+1] : gt[i];
    end
  end

  assign count_post = count_i - CNT_W'(pop_i);

  always_comb begin
    pos_mid = count_post;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (gt_post[i]) pos_mid = CNT_W'(i);
    end
  end

  always_comb begin
    if (!push_i || !need_i)       kind_o = INS_DROP;
    else if (count_i == '0)       kind_o = INS_EMPTY;
    else if (gt_post == '0)       kind_o = INS_APPEND;
    else                          kind_o = INS_MIDDLE;
  end

  assign pos_o = (kind_o == INS_MIDDLE) ? pos_mid : count_post;
endmodule

// File: rtl/rq_store.sv
module rq_store #(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic              pop_i,
  input  logic [TIME_W-1:0] new_time_i,
  input  logic [TAG_W-1:0]  new_tag_i,
  output logic [TIME_W-1:0] slot_time_o [DEPTH],
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [TIME_W-1:0] time_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [TIME_W-1:0] time_p [DEPTH];
  logic [TAG_W-1:0]  tag_p  [DEPTH];
  logic [CNT_W-1:0]  count_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_top
      assign time_p[i] = pop_i ? '0 : time_q[i];
      assign tag_p[i]  = pop_i ? '0 : tag_q[i];
    end else begin : g_low
      assign time_p[i] = pop_i ? time_q[i+1] : time_q[i];
      assign tag_p[i]  = pop_i ? tag_q[i+1]  : tag_q[i];
    end

    logic [TIME_W-1:0] time_d;
    logic [TAG_W-1:0]  tag_d;

    if (i == 0) begin : g_head
      always_comb begin
        time_d = time_p[i];
        tag_d  = tag_p[i];
        if (ins_i && pos_i == CNT_W'(i)) begin
          time_d = new_time_i;
          tag_d  = new_tag_i;
        end
      end
    end else begin : g_body
      always_comb begin
        time_d = time_p[i];
        tag_d  = tag_p[i];
        if (ins_i && pos_i == CNT_W'(i)) begin
          time_d = new_time_i;
          tag_d  = new_tag_i;
        end else if (ins_i && pos_i < CNT_W'(i)) begin
          time_d = time_p[i-1];
          tag_d  = tag_p[i-1];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        time_q[i] <= '0;
        tag_q[i]  <= '0;
      end else begin
        time_q[i] <= time_d;
        tag_q[i]  <= tag_d;
      end
    end

    if (i > 0) begin : g_ord
      AST_SORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_q > CNT_W'(i)) |-> (time_q[i-1] <= time_q[i])); // R5
    end

    assign slot_time_o[i] = time_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q - CNT_W'(pop_i) + CNT_W'(ins_i);
  end

  assign head_tag_o = tag_q[0];
  assign count_o    = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0); // R2
endmodule

// File: rtl/rq_wake.sv
module rq_wake #(
  parameter int TIME_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] head_time_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              due_o
);
  // timer is armed whenever a head exists; fires once its time is reached
  logic armed;
  assign armed = count_i != '0;
  assign due_o = armed && (now_i >= head_time_i);
endmodule

// File: rtl/rq_lat_acc.sv
module rq_lat_acc #(
  parameter int TIME_W = 16,
  parameter int ACC_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              miss_i,
  input  logic              cacheable_i,
  input  logic [TIME_W-1:0] ready_time_i,
  input  logic [TIME_W-1:0] issue_time_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [TIME_W-1:0] delta;
  logic              add;
  logic [ACC_W-1:0]  acc_q;

  assign delta = ready_time_i - issue_time_i;
  assign add   = fire_i && miss_i && cacheable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  acc_q <= '0;
    else if (add) acc_q <= acc_q + ACC_W'(delta);
  end

  assign acc_o = acc_q;

  AST_LAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_i && miss_i && cacheable_i) |=> $stable(acc_o)); // R8
endmodule

// File: rtl/rq_resp_queue.sv
module rq_resp_queue
  import rq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  parameter int TAG_W  = 8,
  parameter int ACC_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] now_i,
  input  logic              enq_valid_i,
  output logic              enq_ready_o,
  input  logic [TIME_W-1:0] enq_time_i,
  input  logic [TAG_W-1:0]  enq_tag_i,
  input  logic              enq_need_rsp_i,
  input  logic              enq_miss_i,
  input  logic              enq_cacheable_i,
  input  logic [TIME_W-1:0] enq_issue_i,
  output logic              deq_valid_o,
  input  logic              deq_ready_i,
  output logic [TAG_W-1:0]  deq_tag_o,
  output logic              empty_o,
  output logic              late_err_o,
  output logic [ACC_W-1:0]  lat_acc_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TIME_W-1:0] slot_time [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  pos;
  ins_kind_e         kind;
  logic              fire;
  logic              pop;
  logic              due;

  assign enq_ready_o = count != CNT_W'(DEPTH);
  assign fire        = enq_valid_i && enq_ready_o;
  assign pop         = due && deq_ready_i;
  assign late_err_o  = enq_valid_i && (enq_time_i < now_i);
  assign empty_o     = count == '0;
  assign deq_valid_o = due;

  rq_place #(.DEPTH(DEPTH), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_place (
    .slot_time_i (slot_time),
    .count_i     (count),
    .new_time_i  (enq_time_i),
    .push_i      (fire),
    .need_i      (enq_need_rsp_i),
    .pop_i       (pop),
    .kind_o      (kind),
    .pos_o       (pos)
  );

  rq_store #(.DEPTH(DEPTH), .TIME_W(TIME_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ins_i       (kind != INS_DROP),
    .pos_i       (pos),
    .pop_i       (pop),
    .new_time_i  (enq_time_i),
    .new_tag_i   (enq_tag_i),
    .slot_time_o (slot_time),
    .head_tag_o  (deq_tag_o),
    .count_o     (count)
  );

  rq_wake #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_wake (
    .now_i       (now_i),
    .head_time_i (slot_time[0]),
    .count_i     (count),
    .due_o       (due)
  );

  rq_lat_acc #(.TIME_W(TIME_W), .ACC_W(ACC_W)) u_lat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .miss_i       (enq_miss_i),
    .cacheable_i  (enq_cacheable_i),
    .ready_time_i (enq_time_i),
    .issue_time_i (enq_issue_i),
    .acc_o        (lat_acc_o)
  );

  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !deq_valid_o); // R2
  AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && !deq_ready_i && !enq_valid_i) |=> (deq_valid_o && $stable(deq_tag_o))); // R2
  AST_DROP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !enq_need_rsp_i && !pop) |=> $stable(empty_o)); // R3
  AST_FULL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enq_ready_o && !pop) |=> !empty_o); // R9
  AST_EMPTY_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && fire && enq_need_rsp_i) |=> !empty_o); // R4
endmodule

// File: tb/rq_resp_queue_test.sv
`timescale 1ns/1ps
module rq_resp_queue_test;
  localparam int DEPTH  = 8;
  localparam int TIME_W = 16;
  localparam int TAG_W  = 8;
  localparam int ACC_W  = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TIME_W-1:0] now = '0;
  logic              enq_valid = 1'b0;
  logic              enq_ready;
  logic [TIME_W-1:0] enq_time = '0;
  logic [TAG_W-1:0]  enq_tag = '0;
  logic              enq_need = 1'b0;
  logic              enq_miss = 1'b0;
  logic              enq_cach = 1'b0;
  logic [TIME_W-1:0] enq_issue = '0;
  logic              deq_valid;
  logic              deq_ready = 1'b0;
  logic [TAG_W-1:0]  deq_tag;
  logic              empty;
  logic              late_err;
  logic [ACC_W-1:0]  lat_acc;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rq_resp_queue #(.DEPTH(DEPTH), .TIME_W(TIME_W), .TAG_W(TAG_W), .ACC_W(ACC_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .now_i(now),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready), .enq_time_i(enq_time),
    .enq_tag_i(enq_tag), .enq_need_rsp_i(enq_need), .enq_miss_i(enq_miss),
    .enq_cacheable_i(enq_cach), .enq_issue_i(enq_issue),
    .deq_valid_o(deq_valid), .deq_ready_i(deq_ready), .deq_tag_o(deq_tag),
    .empty_o(empty), .late_err_o(late_err), .lat_acc_o(lat_acc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_now(input int v);
    @(negedge clk);
    now = TIME_W'(v);
    #1;
  endtask

  task automatic enq(input int t, input int tg, input bit need, input bit miss,
                     input bit cach, input int iss);
    @(negedge clk);
    enq_valid = 1'b1; enq_time = TIME_W'(t); enq_tag = TAG_W'(tg);
    enq_need = need; enq_miss = miss; enq_cach = cach; enq_issue = TIME_W'(iss);
    @(posedge clk); #1;
    enq_valid = 1'b0; enq_need = 1'b0; enq_miss = 1'b0; enq_cach = 1'b0;
  endtask

  task automatic pop_expect(input int tg, input string req);
    @(negedge clk);
    chk(deq_valid === 1'b1, req, int'(deq_valid), 1);
    chk(deq_tag === TAG_W'(tg), req, int'(deq_tag), tg);
    deq_ready = 1'b1;
    @(posedge clk); #1;
    deq_ready = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(empty === 1'b1, "R1", int'(empty), 1);
    chk(deq_valid === 1'b0, "R1", int'(deq_valid), 0);
    chk(enq_ready === 1'b1, "R1", int'(enq_ready), 1);
    chk(lat_acc === '0, "R1", int'(lat_acc), 0);
  endtask

  task automatic t_empty_arm();
    set_now(10);
    enq(15, 8'hA1, 1, 0, 0, 0);
    chk(deq_valid === 1'b0, "R4 before due", int'(deq_valid), 0);
    chk(empty === 1'b0, "R9 occupancy", int'(empty), 0);
    set_now(14);
    chk(deq_valid === 1'b0, "R4 one short", int'(deq_valid), 0);
    set_now(15);
    pop_expect(8'hA1, "R4 due");
    chk(empty === 1'b1, "R2 removed", int'(empty), 1);
  endtask

  task automatic t_order();
    set_now(20);
    enq(30, 1, 1, 0, 0, 0);
    enq(40, 2, 1, 0, 0, 0);
    enq(35, 3, 1, 0, 0, 0);
    enq(30, 4, 1, 0, 0, 0);
    enq(50, 5, 1, 0, 0, 0);
    enq(40, 6, 1, 0, 0, 0);
    set_now(100);
    pop_expect(1, "R5 order");
    pop_expect(4, "R6 equal after");
    pop_expect(3, "R6 middle");
    pop_expect(2, "R5 order");
    pop_expect(6, "R6 equal after");
    pop_expect(5, "R5 tail");
    chk(empty === 1'b1, "R2 drained", int'(empty), 1);
  endtask

  task automatic t_head_insert();
    set_now(100);
    enq(160, 7, 1, 0, 0, 0);
    enq(155, 8, 1, 0, 0, 0);
    set_now(170);
    pop_expect(8, "R6 before head");
    pop_expect(7, "R6 before head");
  endtask

  task automatic t_drop();
    set_now(180);
    @(negedge clk);
    enq_valid = 1'b1; enq_time = TIME_W'(180); enq_tag = 8'h09; enq_need = 1'b0;
    #1;
    chk(enq_ready === 1'b1, "R3 accepted", int'(enq_ready), 1);
    @(posedge clk); #1;
    enq_valid = 1'b0;
    chk(empty === 1'b1, "R3 not stored", int'(empty), 1);
    chk(deq_valid === 1'b0, "R3 not stored", int'(deq_valid), 0);
  endtask

  task automatic t_late();
    set_now(200);
    @(negedge clk);
    enq_valid = 1'b1; enq_time = TIME_W'(200); enq_tag = 8'h10; enq_need = 1'b0;
    #1;
    chk(late_err === 1'b0, "R7 on time", int'(late_err), 0);
    enq_time = TIME_W'(150); enq_tag = 8'h11; enq_need = 1'b1;
    #1;
    chk(late_err === 1'b1, "R7 late", int'(late_err), 1);
    @(posedge clk); #1;
    enq_valid = 1'b0; enq_need = 1'b0;
    pop_expect(8'h11, "R7 still stored");
  endtask

  task automatic t_lat();
    set_now(280);
    enq(300, 20, 1, 1, 1, 280);
    enq(310, 21, 1, 1, 0, 200);
    enq(320, 22, 1, 0, 1, 200);
    enq(330, 23, 0, 1, 1, 320);
    @(negedge clk);
    chk(lat_acc === ACC_W'(30), "R8 accumulate", int'(lat_acc), 30);
    set_now(330);
    pop_expect(20, "R8 drain");
    pop_expect(21, "R8 drain");
    pop_expect(22, "R8 drain");
    chk(empty === 1'b1, "R3 dropped miss", int'(empty), 1);
  endtask

  task automatic t_full();
    set_now(400);
    for (int i = 0; i < DEPTH; i++) enq(500 + i, 40 + i, 1, 0, 0, 0);
    chk(enq_ready === 1'b0, "R9 full", int'(enq_ready), 0);
    chk(empty === 1'b0, "R9 full", int'(empty), 0);
    @(negedge clk);
    enq_valid = 1'b1; enq_time = TIME_W'(450); enq_tag = 8'h63; enq_need = 1'b1;
    @(posedge clk); #1;
    enq_valid = 1'b0; enq_need = 1'b0;
    set_now(510);
    for (int i = 0; i < DEPTH; i++) pop_expect(40 + i, "R9 rejected");
    chk(empty === 1'b1, "R9 drained", int'(empty), 1);
    chk(enq_ready === 1'b1, "R9 ready", int'(enq_ready), 1);
  endtask

  task automatic t_simul();
    set_now(600);
    enq(600, 8'h70, 1, 0, 0, 0);
    @(negedge clk);
    enq_valid = 1'b1; enq_time = TIME_W'(650); enq_tag = 8'h71; enq_need = 1'b1;
    deq_ready = 1'b1;
    #1;
    chk(deq_valid === 1'b1, "R10 head due", int'(deq_valid), 1);
    chk(deq_tag === 8'h70, "R10 head tag", int'(deq_tag), 8'h70);
    @(posedge clk); #1;
    enq_valid = 1'b0; enq_need = 1'b0; deq_ready = 1'b0;
    chk(deq_valid === 1'b0, "R10 new not due", int'(deq_valid), 0);
    chk(empty === 1'b0, "R10 new stored", int'(empty), 0);
    set_now(650);
    pop_expect(8'h71, "R10 new head");
    chk(empty === 1'b1, "R10 drained", int'(empty), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty_arm();
    t_order();
    t_head_insert();
    t_drop();
    t_late();
    t_lat();
    t_full();
    t_simul();
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule